// File: doc/BRIEF.md
# Systolic Matrix-Vector Product Array

The block forms y = A·x for a square N×N matrix (N = 4 by default) of signed Q9.23 words. It is a linear chain of N processing elements. Element j keeps the running sum for output y_j. A start pulse arms the block and clears every sum. The host then offers N columns, one per accepted beat. Each beat carries the N words of column i of A and the vector element x_i.

The block does not broadcast x_i to all elements. A skewing stage delays row j of each column by j cycles and puts zeros in the empty slots. The vector element walks down the chain through one register between each pair of neighbours. As a result, a(j,i) and x_i meet in element j exactly j cycles after column i is taken. Each product is scaled back to Q9.23 and clamped. It is then added into the element's sum, and that addition also saturates. When an element has absorbed its N-th operand, it raises a one-cycle valid for its output word. The word then stays on the output until the next start.

Top module: `mvSystolic`

## Requirements
- R1: After reset, and in the cycle after any start pulse, every output word reads zero and no valid is high. A start pulse also discards every column still in flight and any column offered in the same cycle.
- R2: y_j is the sum over i of the scaled product of a(j,i) and x_i. Words are 32-bit two's complement with 23 fraction bits. Row j of a column travels on colData bits [32j+31:32j].
- R3: Each 64-bit product is shifted right arithmetically by 23 bits, which rounds toward minus infinity. The result is then clamped to the range 0x80000000 to 0x7FFFFFFF.
- R4: Each addition into a sum saturates to the same bounds. Accumulation order follows column order, so a clamped sum can later move back away from the bound.
- R5: yValid[j] is a one-cycle pulse. It appears in the cycle after the clock edge at which element j takes its N-th operand. With columns on consecutive edges starting at edge E, y_j is valid after edge E+N-1+j.
- R6: Idle cycles between columns delay the schedule but do not change any result. Element j still sees each column exactly j edges after it is taken.
- R7: Columns offered before the first start, or after N columns have been taken, are ignored.
- R8: After its valid pulse, y_j holds its value until the next start.
- R9: Valids arrive in element order: y_j becomes valid one cycle after y_(j-1). No two valids are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Clears the sums and arms the block for N columns |
| colValid | input | 1 | Qualifies colData and xIn in this cycle |
| colData | input | N*32 | One matrix column; row j in bits [32j+31:32j] |
| xIn | input | 32 | Vector element paired with this column |
| yValid | output | N | Bit j pulses when y_j is complete |
| yOut | output | N*32 | y_j in bits [32j+31:32j] |

## Verification
The bench uses several kinds of matrix. An identity matrix with fractional x values shows that the scaling returns x exactly. Mixed-sign matrices on back-to-back columns fix the exact valid cycle of each element. The same kind of data with idle gaps shows that the neighbour registers keep the operands paired. Large operands exercise the product clamp, and a tiny negative product exercises rounding toward minus infinity. Rows whose sums pass a bound and then come back show that the sum saturates at each step rather than once at the end. Columns offered before arming, after the N-th column, or cut off by a mid-stream start must leave no trace in the outputs.

// File: rtl/mvPkg.sv
package mvPkg;
  // Control strobes sent from the sequencer to the datapath.
  typedef struct packed {
    logic clear;  // zero sums, skew slots and neighbour registers
    logic take;   // the column on the inputs is accepted this cycle
  } mvStrobeT;
endpackage

// File: rtl/mvPe.sv
module mvPe #(
  parameter int N    = 4,
  parameter int W    = 32,
  parameter int FRAC = 23
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clear,
  input  logic signed [W-1:0] aIn,
  input  logic signed [W-1:0] xIn,
  input  logic                vIn,
  output logic [W-1:0]        acc,
  output logic                done
);
  localparam int CW = $clog2(N + 1);
  localparam logic signed [2*W-1:0] PMAX = {{(W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [2*W-1:0] PMIN = {{(W+1){1'b1}}, {(W-1){1'b0}}};
  localparam logic [W-1:0] WMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] WMIN = {1'b1, {(W-1){1'b0}}};

  logic signed [2*W-1:0] prod, prodSh;
  logic [W-1:0]          term, nextAcc;
  logic [W:0]            sum;
  logic [CW-1:0]         cnt;

  always_comb begin
    prod   = aIn * xIn;
    prodSh = prod >>> FRAC;
    if (prodSh > PMAX)      term = WMAX;
    else if (prodSh < PMIN) term = WMIN;
    else                    term = prodSh[W-1:0];
    sum = {acc[W-1], acc} + {term[W-1], term};
    if (sum[W] != sum[W-1]) nextAcc = sum[W] ? WMIN : WMAX;
    else                    nextAcc = sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      acc  <= '0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= vIn && (cnt == CW'(N - 1));
      if (vIn) begin
        acc <= nextAcc;
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mvCtrl.sv
module mvCtrl
  import mvPkg::*;
#(
  parameter int N = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     colValid,
  output mvStrobeT strobe
);
  localparam int CW = $clog2(N + 1);

  logic          armed;
  logic [CW-1:0] taken;

  always_comb begin
    strobe.clear = start;
    strobe.take  = colValid && armed && !start;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed <= 1'b0;
      taken <= '0;
    end else if (start) begin
      armed <= 1'b1;
      taken <= '0;
    end else if (strobe.take) begin
      taken <= taken + 1'b1;
      if (taken == CW'(N - 1)) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/mvDatapath.sv
module mvDatapath
  import mvPkg::*;
#(
  parameter int N    = 4,
  parameter int W    = 32,
  parameter int FRAC = 23
) (
  input  logic           clk,
  input  logic           rstN,
  input  mvStrobeT       strobe,
  input  logic [N*W-1:0] colData,
  input  logic [W-1:0]   xIn,
  output logic [N-1:0]   yValid,
  output logic [N*W-1:0] yOut
);
  for (genvar j = 0; j < N; j++) begin : lane
    logic [W-1:0] aHere, xHere;
    logic         vHere;

    if (j == 0) begin : g_head
      assign aHere = strobe.take ? colData[W-1:0] : '0;
      assign xHere = strobe.take ? xIn : '0;
      assign vHere = strobe.take;
    end else begin : g_body
      // Row skew: j slots deep, zero-filled when no column is taken.
      logic [W-1:0] skew [j];
      logic [W-1:0] xReg;
      logic         vReg;

      always_ff @(posedge clk) begin
        if (!rstN || strobe.clear) begin
          for (int k = 0; k < j; k++) skew[k] <= '0;
          xReg <= '0;
          vReg <= 1'b0;
        end else begin
          skew[0] <= strobe.take ? colData[j*W +: W] : '0;
          for (int k = 1; k < j; k++) skew[k] <= skew[k-1];
          // neighbour-only hand-off of the vector element
          xReg <= lane[j-1].xHere;
          vReg <= lane[j-1].vHere;
        end
      end

      assign aHere = skew[j-1];
      assign xHere = xReg;
      assign vHere = vReg;
    end

    mvPe #(.N(N), .W(W), .FRAC(FRAC)) uPe (
      .clk  (clk),
      .rstN (rstN),
      .clear(strobe.clear),
      .aIn  (aHere),
      .xIn  (xHere),
      .vIn  (vHere),
      .acc  (yOut[j*W +: W]),
      .done (yValid[j])
    );
  end
endmodule

// File: rtl/mvSystolic.sv
module mvSystolic
  import mvPkg::*;
#(
  parameter int N    = 4,
  parameter int W    = 32,
  parameter int FRAC = 23
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic           colValid,
  input  logic [N*W-1:0] colData,
  input  logic [W-1:0]   xIn,
  output logic [N-1:0]   yValid,
  output logic [N*W-1:0] yOut
);
  mvStrobeT strobe;

  mvCtrl #(.N(N)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .colValid(colValid),
    .strobe  (strobe)
  );

  mvDatapath #(.N(N), .W(W), .FRAC(FRAC)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .colData(colData),
    .xIn    (xIn),
    .yValid (yValid),
    .yOut   (yOut)
  );
endmodule

// File: rtl/mvSystolicChk.sv
module mvSystolicChk #(
  parameter int N = 4,
  parameter int W = 32
) (
  input logic           clk,
  input logic           rstN,
  input logic           start,
  input logic [N-1:0]   yValid,
  input logic [N*W-1:0] yOut
);
  logic [N-1:0] doneSeen;

  always_ff @(posedge clk) begin
    if (!rstN)      doneSeen <= '0;
    else if (start) doneSeen <= '0;
    else            doneSeen <= doneSeen | yValid;
  end

  p_valid_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(yValid));

  p_start_clears_r1: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (yValid == '0) && (yOut == '0));

  for (genvar j = 0; j < N; j++) begin : g_el
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
      yValid[j] |=> !yValid[j]);

    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
      ((yValid[j] || doneSeen[j]) && !start) |=> $stable(yOut[j*W +: W]));

    if (j > 0) begin : g_ord
      p_valid_order_r9: assert property (@(posedge clk) disable iff (!rstN)
        yValid[j] |-> $past(yValid[j-1]));
    end
  end
endmodule

bind mvSystolic mvSystolicChk #(.N(N), .W(W)) uChk (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .yValid(yValid),
  .yOut  (yOut)
);

// File: tb/sim_mvSystolic.sv
`timescale 1ns/1ps
module sim_mvSystolic;
  localparam int N = 4, W = 32, FRAC = 23;
  localparam int QMAX = 32'h7FFF_FFFF;
  localparam int QMIN = 32'h8000_0000;
  localparam int ONE  = 1 << FRAC;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, colValid = 1'b0;
  logic [N*W-1:0] colData = '0;
  logic [W-1:0]   xIn = '0;
  wire  [N-1:0]   yValid;
  wire  [N*W-1:0] yOut;

  always #10 clk = ~clk;

  mvSystolic #(.N(N), .W(W), .FRAC(FRAC)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .colValid(colValid),
    .colData(colData), .xIn(xIn), .yValid(yValid), .yOut(yOut)
  );

  int tests = 0, fails = 0, cyc = 0, multiValid = 0, e0 = 0;
  bit finished = 0;

  // behavioural reference
  int mAcc [N], mCnt [N], colEdge [N], colX [N], colA [N][N];
  int nTaken = 0;
  bit armed = 0;
  logic [N-1:0] mValid = '0;
  int seenAt [N];
  int tA [N][N], tX [N], saved [N];

  function automatic int satMul(int a, int b);
    longint p = (longint'(a) * longint'(b)) >>> FRAC;
    if (p > longint'(QMAX)) return QMAX;
    if (p < longint'(QMIN)) return QMIN;
    return int'(p);
  endfunction

  function automatic int satAdd(int a, int b);
    longint s = longint'(a) + longint'(b);
    if (s > longint'(QMAX)) return QMAX;
    if (s < longint'(QMIN)) return QMIN;
    return int'(s);
  endfunction

  function automatic int outWord(int j);
    return int'($signed(yOut[j*W +: W]));
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL R5 watchdog: actual cycle %0d, expected end before 20000", cyc);
      summary();
    end
    if (!rstN) begin
      armed = 0; nTaken = 0; mValid = '0;
      for (int j = 0; j < N; j++) begin mAcc[j] = 0; mCnt[j] = 0; end
    end else begin
      mValid = '0;
      if (start) begin
        armed = 1; nTaken = 0;
        for (int j = 0; j < N; j++) begin mAcc[j] = 0; mCnt[j] = 0; end
      end else begin
        if (colValid && armed) begin
          colEdge[nTaken] = cyc;
          for (int j = 0; j < N; j++) colA[j][nTaken] = int'($signed(colData[j*W +: W]));
          colX[nTaken] = int'($signed(xIn));
          nTaken++;
          if (nTaken == N) armed = 0;
        end
        for (int j = 0; j < N; j++)
          for (int k = 0; k < nTaken; k++)
            if (colEdge[k] + j == cyc) begin
              mAcc[j] = satAdd(mAcc[j], satMul(colA[j][k], colX[k]));
              mCnt[j]++;
              if (mCnt[j] == N) mValid[j] = 1'b1;
            end
      end
    end
  end

  // per-cycle comparison against the reference (R5 timing, R2 values)
  always @(negedge clk) begin
    if (rstN && !finished) begin
      tests++;
      if (yValid !== mValid) begin
        fails++;
        $display("FAIL R5 cycle %0d: yValid actual %b expected %b", cyc, yValid, mValid);
      end
      for (int j = 0; j < N; j++)
        if (outWord(j) !== mAcc[j]) begin
          fails++;
          $display("FAIL R2 cycle %0d y%0d: actual %h expected %h", cyc, j, outWord(j), mAcc[j]);
        end
      if ($countones(yValid) > 1) multiValid++;
      for (int j = 0; j < N; j++) if (yValid[j]) seenAt[j] = cyc;
    end
  end

  task automatic checkEq(string tag, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulseStart();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic loadCol(int i);
    for (int j = 0; j < N; j++) colData[j*W +: W] = tA[j][i];
    xIn = tX[i];
  endtask

  task automatic runSet(bit gaps);
    for (int j = 0; j < N; j++) seenAt[j] = -1;
    pulseStart();
    for (int i = 0; i < N; i++) begin
      if (gaps) begin
        colValid = 1'b0;
        repeat (1 + (i % 2) + (i == 2 ? 2 : 0)) @(negedge clk);
      end
      loadCol(i);
      colValid = 1'b1;
      if (i == 0) e0 = cyc + 1;
      @(negedge clk);
    end
    colValid = 1'b0;
    repeat (3 * N) @(negedge clk);
  endtask

  task automatic setIdentity();
    for (int j = 0; j < N; j++)
      for (int i = 0; i < N; i++) tA[j][i] = (i == j) ? ONE : 0;
    tX[0] = 12582912; tX[1] = -16777216; tX[2] = 27262976; tX[3] = 1048576;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    checkEq("R1 reset valid", int'(yValid), 0);
    for (int j = 0; j < N; j++) checkEq("R1 reset word", outWord(j), 0);

    // R7: column before any start is ignored
    setIdentity();
    loadCol(0); colValid = 1'b1;
    @(negedge clk);
    colValid = 1'b0;
    repeat (8) @(negedge clk);
    checkEq("R7 pre-start word", outWord(0), 0);

    // R2: identity, exact scaling
    runSet(0);
    for (int j = 0; j < N; j++) checkEq("R2 identity", outWord(j), tX[j]);

    // R5: mixed-sign matrix, valid timing on back-to-back columns
    for (int j = 0; j < N; j++)
      for (int i = 0; i < N; i++)
        tA[j][i] = (((j * 4 + i + 1) << 20) * (((i + j) % 2 != 0) ? -1 : 1));
    for (int i = 0; i < N; i++) tX[i] = (i + 1) << 22;
    runSet(0);
    for (int j = 0; j < N; j++) begin
      checkEq("R5 valid edge", seenAt[j], e0 + N - 1 + j);
      checkEq("R2 mixed", outWord(j), mAcc[j]);
    end

    // R7: extra column after N taken; R8: hold
    for (int j = 0; j < N; j++) saved[j] = outWord(j);
    loadCol(1); colValid = 1'b1;
    @(negedge clk);
    colValid = 1'b0;
    repeat (10) @(negedge clk);
    for (int j = 0; j < N; j++) checkEq("R7 extra column", outWord(j), saved[j]);
    repeat (20) @(negedge clk);
    for (int j = 0; j < N; j++) checkEq("R8 hold", outWord(j), saved[j]);

    // R6: random data with idle gaps
    for (int j = 0; j < N; j++)
      for (int i = 0; i < N; i++) tA[j][i] = int'($urandom_range(0, 1 << 26)) - (1 << 25);
    for (int i = 0; i < N; i++) tX[i] = int'($urandom_range(0, 1 << 26)) - (1 << 25);
    runSet(1);
    for (int j = 0; j < N; j++) checkEq("R6 gapped result", outWord(j), mAcc[j]);
    for (int j = 1; j < N; j++) checkEq("R6 neighbour spacing", seenAt[j] - seenAt[j-1], 1);

    // R3: product clamp and floor rounding
    for (int j = 0; j < N; j++) for (int i = 0; i < N; i++) tA[j][i] = 0;
    tX[0] = 200 * ONE; tX[1] = 3; tX[2] = 0; tX[3] = 0;
    tA[0][0] = 200 * ONE;
    tA[1][1] = -1;
    tA[2][0] = -200 * ONE;
    runSet(0);
    checkEq("R3 positive clamp", outWord(0), QMAX);
    checkEq("R3 floor shift", outWord(1), -1);
    checkEq("R3 negative clamp", outWord(2), QMIN);
    checkEq("R3 zero row", outWord(3), 0);

    // R4: accumulator saturation per step
    for (int i = 0; i < N; i++) begin
      tX[i] = 15 * ONE;
      tA[0][i] = 15 * ONE;
      tA[1][i] = -15 * ONE;
      tA[2][i] = (i % 2 == 0) ? 15 * ONE : -15 * ONE;
      tA[3][i] = (i < 2) ? 10 * ONE : -10 * ONE;
    end
    runSet(0);
    checkEq("R4 high bound", outWord(0), QMAX);
    checkEq("R4 low bound", outWord(1), QMIN);
    checkEq("R4 no clamp", outWord(2), 0);
    checkEq("R4 clamp then return", outWord(3), int'(32'hE9FF_FFFF));

    // R1: start clears
    pulseStart();
    checkEq("R1 start valid", int'(yValid), 0);
    for (int j = 0; j < N; j++) checkEq("R1 start word", outWord(j), 0);

    // R1: start mid-stream discards in-flight columns
    for (int j = 0; j < N; j++) for (int i = 0; i < N; i++) tA[j][i] = 7 * ONE;
    for (int i = 0; i < N; i++) tX[i] = 5 * ONE;
    loadCol(0); colValid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    colValid = 1'b0;
    setIdentity();
    runSet(0);
    for (int j = 0; j < N; j++) checkEq("R1 restart", outWord(j), tX[j]);

    // R9: never two valids together
    checkEq("R9 overlapping valids", multiValid, 0);
    summary();
  end
endmodule